// File: doc/BRIEF.md
# Sector DMA Request Controller

This block paces a sector-by-sector transfer between a flash-style storage engine and a host DMA engine. Software programs two 16-bit control words over a simple register bus: the first holds the enable, pause, request-shape and polarity bits together with the number of 512-byte sectors to move (stored minus one); the second holds the data-count value at which a level-style request is released. Once enabled, the block raises a DMA request at the start of each sector, waits for the ECC logic to report that the sector's checksum has been read, and then either moves on to the next sector, finishes, or stops on an ECC error until software clears the pause bit.

The request pin is either a fixed-width pulse of about 250 ns (the width in cycles is derived from the clock period parameter) or a level that is released combinationally in the very cycle the data path's per-sector count equals the programmed release count. Its idle level is selected by a polarity bit.

The control flow is a three-state machine. `ST_IDLE` waits for enable set and pause clear (transition *go*). `ST_ASSERT` drives the request; it moves to `ST_ECC_WAIT` when the pulse timer expires (pulse shape) or when the data count matches the release count (level shape). `ST_ECC_WAIT` waits for the ECC strobe: a clean strobe with sectors left decrements the count and returns to `ST_ASSERT` (*next sector*); a clean strobe on the last sector clears enable, pulses done and returns to `ST_IDLE` (*finish*); a strobe with error sets pause and returns to `ST_IDLE` (*halt*). From `ST_ASSERT` or `ST_ECC_WAIT`, enable cleared or pause set returns to `ST_IDLE` (*abort*).

Top module: `sdma_req_ctrl`

## Requirements
- R1: Control word 0 (reg_sel=0) has enable at bit 0, pause at bit 1, pulse shape at bit 2 (1 = pulse, 0 = level), active-high polarity at bit 3 and sectors-minus-one at bits 14:4; bit 15 reads 0. Control word 1 (reg_sel=1) holds the release count in bits 8:0 and reads 0 above. reg_rdata shows the word chosen by reg_sel.
- R2: While enable is 0 or pause is 1, dreq_o stays at its idle level.
- R3: With polarity 0 the request idles high and is asserted low; with polarity 1 it idles low and is asserted high.
- R4: In pulse shape each request is asserted for exactly PULSE_CYCLES clock cycles, which is 31 with the default 8 ns clock period.
- R5: In level shape the request is asserted from the start of the sector and negates in the same cycle in which data_cnt equals the release count; it stays negated until the next sector.
- R6: A single-cycle ecc_strobe with ecc_err=0 after a request, with a nonzero sector count, decrements the count by one and starts the next request.
- R7: An ecc_strobe with ecc_err=1 sets pause and leaves the sector count unchanged; no request follows until software writes pause back to 0, after which the same sector is requested again.
- R8: A clean ecc_strobe when the sector count is 0 raises done_o for that one cycle, clears enable on the following edge, and no further request is issued.
- R9: A write to control word 0 while enable is 1 and pause is 0 leaves the sector count unchanged; at any other time the written count is taken.
- R10: After reset both control words read 0, dreq_o is high and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wen | input | 1 | Register write strobe |
| reg_sel | input | 1 | Selects control word 0 or 1 |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected control word |
| data_cnt | input | DCNT_W (9) | Per-sector data count from the data path |
| ecc_strobe | input | 1 | One-cycle pulse: sector checksum has been read |
| ecc_err | input | 1 | ECC error flag, valid with ecc_strobe |
| dreq_o | output | 1 | DMA request pin, polarity per control word 0 |
| done_o | output | 1 | One-cycle flag: last sector finished cleanly |

## Verification
The assertions take for granted that ecc_strobe is a single-cycle pulse issued only after the request for the current sector has negated, that the request shape is not changed while a request is active, and that software writes do not land in the same cycle as an ECC strobe. The directed stimulus respects this by waiting until dreq_o is seen back at its idle level before pulsing ecc_strobe, by changing shape and polarity only with enable clear, and by issuing register writes only when no strobe is pending.

// File: rtl/sdma_pkg.sv
`timescale 1ns/1ps
package sdma_pkg;

    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ASSERT   = 2'd1,
        ST_ECC_WAIT = 2'd2
    } sdma_state_e;

endpackage

// File: rtl/sdma_regs.sv
`timescale 1ns/1ps
module sdma_regs #(
    parameter int CNT_W  = 11,
    parameter int DCNT_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wen,
    input  logic                     sel,
    input  logic [sdma_pkg::REG_W-1:0] wdata,
    output logic [sdma_pkg::REG_W-1:0] rdata,
    input  logic                     hw_dec,
    input  logic                     hw_pause,
    input  logic                     hw_finish,
    output logic                     en,
    output logic                     hold,
    output logic                     pulse_mode,
    output logic                     act_high,
    output logic [CNT_W-1:0]         sec_cnt,
    output logic [DCNT_W-1:0]        neg_cnt
);
    localparam int CNT_LSB = 4;

    logic unused_wbits;
    assign unused_wbits = ^wdata;

    // count is writable only when no transfer is running
    logic cnt_locked;
    assign cnt_locked = en && !hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en         <= 1'b0;
            hold       <= 1'b0;
            pulse_mode <= 1'b0;
            act_high   <= 1'b0;
            sec_cnt    <= '0;
            neg_cnt    <= '0;
        end else begin
            if (wen && !sel) begin
                en         <= wdata[0];
                hold       <= wdata[1];
                pulse_mode <= wdata[2];
                act_high   <= wdata[3];
                if (!cnt_locked)
                    sec_cnt <= wdata[CNT_LSB +: CNT_W];
            end
            if (wen && sel)
                neg_cnt <= wdata[DCNT_W-1:0];
            // hardware events take precedence over software
            if (hw_dec)
                sec_cnt <= sec_cnt - CNT_W'(1);
            if (hw_pause)
                hold <= 1'b1;
            if (hw_finish)
                en <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (!sel) begin
            rdata[0] = en;
            rdata[1] = hold;
            rdata[2] = pulse_mode;
            rdata[3] = act_high;
            rdata[CNT_LSB +: CNT_W] = sec_cnt;
        end else begin
            rdata[DCNT_W-1:0] = neg_cnt;
        end
    end

endmodule

// File: rtl/sdma_pulse_timer.sv
`timescale 1ns/1ps
module sdma_pulse_timer #(
    parameter int PULSE_CYCLES = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(PULSE_CYCLES + 1);

    logic [TW-1:0] cnt;

    assign expired = (cnt == TW'(PULSE_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (run && !expired)
            cnt <= cnt + TW'(1);
    end

endmodule

// File: rtl/sdma_req_fsm.sv
`timescale 1ns/1ps
module sdma_req_fsm #(
    parameter int DCNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hold,
    input  logic              pulse_mode,
    input  logic              act_high,
    input  logic              sec_last,
    input  logic              tmr_exp,
    input  logic [DCNT_W-1:0] data_cnt,
    input  logic [DCNT_W-1:0] neg_cnt,
    input  logic              ecc_strobe,
    input  logic              ecc_err,
    output logic              tmr_clr,
    output logic              tmr_run,
    output logic              hw_dec,
    output logic              hw_pause,
    output logic              hw_finish,
    output logic              in_wait,
    output logic              dreq_o,
    output logic              done_o
);
    import sdma_pkg::*;

    sdma_state_e state, state_nxt;

    logic go, match, ecc_ev, active;

    assign go    = en && !hold;
    assign match = (data_cnt == neg_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (go)
                    state_nxt = ST_ASSERT;
            end
            ST_ASSERT: begin
                if (!go)
                    state_nxt = ST_IDLE;
                else if (pulse_mode ? tmr_exp : match)
                    state_nxt = ST_ECC_WAIT;
            end
            ST_ECC_WAIT: begin
                if (!go)
                    state_nxt = ST_IDLE;
                else if (ecc_strobe) begin
                    if (ecc_err || sec_last)
                        state_nxt = ST_IDLE;
                    else
                        state_nxt = ST_ASSERT;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_run   = (state == ST_ASSERT);
        tmr_clr   = (state != ST_ASSERT);
        in_wait   = (state == ST_ECC_WAIT);
        ecc_ev    = in_wait && go && ecc_strobe;
        hw_pause  = ecc_ev && ecc_err;
        hw_dec    = ecc_ev && !ecc_err && !sec_last;
        hw_finish = ecc_ev && !ecc_err && sec_last;
        done_o    = hw_finish;
        active    = (state == ST_ASSERT) && go && (pulse_mode || !match);
        dreq_o    = act_high ? active : !active;
    end

endmodule

// File: rtl/sdma_req_ctrl.sv
`timescale 1ns/1ps
module sdma_req_ctrl #(
    parameter int CLK_PS   = 8000,
    parameter int PULSE_NS = 250,
    parameter int CNT_W    = 11,
    parameter int DCNT_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic              reg_sel,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [DCNT_W-1:0] data_cnt,
    input  logic              ecc_strobe,
    input  logic              ecc_err,
    output logic              dreq_o,
    output logic              done_o
);
    localparam int PULSE_RAW    = (PULSE_NS * 1000 + CLK_PS / 2) / CLK_PS;
    localparam int PULSE_CYCLES = (PULSE_RAW < 1) ? 1 : PULSE_RAW;

    logic en, hold, pulse_mode, act_high;
    logic [CNT_W-1:0]  sec_cnt;
    logic [DCNT_W-1:0] neg_cnt;
    logic hw_dec, hw_pause, hw_finish;
    logic tmr_clr, tmr_run, tmr_exp, in_wait;

    sdma_regs #(.CNT_W(CNT_W), .DCNT_W(DCNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wen(reg_wen), .sel(reg_sel), .wdata(reg_wdata), .rdata(reg_rdata),
        .hw_dec(hw_dec), .hw_pause(hw_pause), .hw_finish(hw_finish),
        .en(en), .hold(hold), .pulse_mode(pulse_mode), .act_high(act_high),
        .sec_cnt(sec_cnt), .neg_cnt(neg_cnt)
    );

    sdma_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clr(tmr_clr), .run(tmr_run), .expired(tmr_exp)
    );

    sdma_req_fsm #(.DCNT_W(DCNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en(en), .hold(hold), .pulse_mode(pulse_mode), .act_high(act_high),
        .sec_last(sec_cnt == '0), .tmr_exp(tmr_exp),
        .data_cnt(data_cnt), .neg_cnt(neg_cnt),
        .ecc_strobe(ecc_strobe), .ecc_err(ecc_err),
        .tmr_clr(tmr_clr), .tmr_run(tmr_run),
        .hw_dec(hw_dec), .hw_pause(hw_pause), .hw_finish(hw_finish),
        .in_wait(in_wait), .dreq_o(dreq_o), .done_o(done_o)
    );

endmodule

// File: rtl/sdma_req_chk.sv
`timescale 1ns/1ps
module sdma_req_chk #(
    parameter int CNT_W        = 11,
    parameter int PULSE_CYCLES = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wen,
    input logic             reg_sel,
    input logic [15:0]      reg_rdata,
    input logic             ecc_strobe,
    input logic             ecc_err,
    input logic             dreq_o,
    input logic             done_o,
    input logic             en,
    input logic             hold,
    input logic             pulse_mode,
    input logic             act_high,
    input logic [CNT_W-1:0] sec_cnt,
    input logic             in_wait
);
    logic        req_on;
    logic [15:0] run_len;

    assign req_on = (dreq_o == act_high);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_len <= '0;
        else if (req_on && run_len != 16'hFFFF)
            run_len <= run_len + 16'd1;
        else if (!req_on)
            run_len <= '0;
    end

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> !reg_rdata[15]);

    a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || hold) |-> (dreq_o == !act_high));

    a_r4_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && req_on) |-> (run_len < 16'(PULSE_CYCLES)));

    a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && en && !hold && ecc_strobe && !ecc_err && sec_cnt != '0)
        |=> (sec_cnt == $past(sec_cnt) - CNT_W'(1)));

    a_r7_error_pauses: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && en && !hold && ecc_strobe && ecc_err && !(reg_wen && !reg_sel))
        |=> (hold && $stable(sec_cnt)));

    a_r8_done_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !en);

    a_r9_count_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && !reg_sel && en && !hold && !(in_wait && ecc_strobe))
        |=> $stable(sec_cnt));

endmodule

bind sdma_req_ctrl sdma_req_chk #(.CNT_W(CNT_W), .PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_sel(reg_sel),
    .reg_rdata(reg_rdata), .ecc_strobe(ecc_strobe), .ecc_err(ecc_err),
    .dreq_o(dreq_o), .done_o(done_o), .en(en), .hold(hold),
    .pulse_mode(pulse_mode), .act_high(act_high), .sec_cnt(sec_cnt),
    .in_wait(in_wait)
);

// File: tb/tb_sdma_req_ctrl.sv
`timescale 1ns/1ps
module tb_sdma_req_ctrl;

    localparam int EXP_PULSE = 31; // 250 ns at an 8 ns period, rounded

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [8:0]  data_cnt = '0;
    logic        ecc_strobe = 1'b0;
    logic        ecc_err = 1'b0;
    logic        dreq_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    logic pol_now = 1'b0;

    always #4 clk = ~clk;

    sdma_req_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_cnt(data_cnt),
        .ecc_strobe(ecc_strobe), .ecc_err(ecc_err), .dreq_o(dreq_o),
        .done_o(done_o)
    );

    function automatic logic [15:0] c0(input logic e, input logic h,
                                       input logic m, input logic p,
                                       input logic [10:0] n);
        return {1'b0, n, p, m, h, e};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
        #1;
    endtask

    task automatic rd(input string req, input logic sel, input logic [15:0] exp);
        reg_sel = sel;
        #1;
        chk(req, int'(reg_rdata), int'(exp));
    endtask

    function automatic logic active();
        return dreq_o == pol_now;
    endfunction

    // returns width of the next request, 0 if none seen
    task automatic next_width(output int w);
        w = 0;
        for (int i = 0; i < 200; i++) begin
            if (active()) break;
            @(negedge clk); #1;
        end
        while (active() && w < 1000) begin
            w++;
            @(negedge clk); #1;
        end
    endtask

    task automatic strobe(input logic e, output logic d);
        ecc_strobe = 1'b1; ecc_err = e;
        #1;
        d = done_o;
        @(negedge clk);
        ecc_strobe = 1'b0; ecc_err = 1'b0;
        #1;
    endtask

    task automatic quiet(input string req, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            if (active()) seen++;
        end
        chk(req, seen, 0);
    endtask

    task automatic t_reset();
        rd("R10 ctrl0 reset", 1'b0, 16'h0000);
        rd("R10 ctrl1 reset", 1'b1, 16'h0000);
        chk("R10 dreq idle high", int'(dreq_o), 1);
        chk("R10 done low", int'(done_o), 0);
    endtask

    task automatic t_fields();
        wr(1'b0, 16'hFFFF);
        rd("R1 ctrl0 reserved bit", 1'b0, 16'h7FFF);
        wr(1'b1, 16'hFFFF);
        rd("R1 ctrl1 upper bits", 1'b1, 16'h01FF);
        wr(1'b0, 16'h0000);
        rd("R1 ctrl0 cleared", 1'b0, 16'h0000);
        wr(1'b1, 16'h0000);
    endtask

    task automatic t_pulse_multi();
        int w; logic d;
        pol_now = 1'b0;
        wr(1'b0, c0(1, 0, 1, 0, 11'd2));
        next_width(w);  chk("R4 R3 first pulse width", w, EXP_PULSE);
        rd("R6 count before strobe", 1'b0, c0(1, 0, 1, 0, 11'd2));
        strobe(1'b0, d); chk("R6 no done mid-run", int'(d), 0);
        rd("R6 count after strobe", 1'b0, c0(1, 0, 1, 0, 11'd1));
        next_width(w);  chk("R6 second pulse", w, EXP_PULSE);
        strobe(1'b0, d);
        rd("R6 count reaches zero", 1'b0, c0(1, 0, 1, 0, 11'd0));
        next_width(w);  chk("R6 third pulse", w, EXP_PULSE);
        strobe(1'b0, d); chk("R8 done on last sector", int'(d), 1);
        chk("R8 done single cycle", int'(done_o), 0);
        rd("R8 enable cleared", 1'b0, c0(0, 0, 1, 0, 11'd0));
        quiet("R8 no request after finish", 60);
    endtask

    task automatic t_polarity_high();
        int w; logic d;
        wr(1'b0, c0(0, 0, 1, 1, 11'd0));
        chk("R3 idle low when active-high", int'(dreq_o), 0);
        pol_now = 1'b1;
        wr(1'b0, c0(1, 0, 1, 1, 11'd0));
        next_width(w);  chk("R3 R4 high pulse width", w, EXP_PULSE);
        strobe(1'b0, d); chk("R8 done single sector", int'(d), 1);
        wr(1'b0, 16'h0000);
        pol_now = 1'b0;
        chk("R3 back to idle high", int'(dreq_o), 1);
    endtask

    task automatic t_level();
        int w; logic d;
        pol_now = 1'b0;
        data_cnt = '0;
        wr(1'b1, 16'd5);
        rd("R1 release count", 1'b1, 16'd5);
        wr(1'b0, c0(1, 0, 0, 0, 11'd0));
        for (int i = 0; i < 20; i++) begin
            if (active()) break;
            @(negedge clk); #1;
        end
        for (int i = 0; i < 8; i++) begin
            data_cnt = 9'(i);
            #1;
            chk("R5 level request vs count", int'(active()), (i < 5) ? 1 : 0);
            @(negedge clk); #1;
        end
        strobe(1'b0, d); chk("R8 level done", int'(d), 1);
        data_cnt = '0;
        w = 0;
        wr(1'b1, 16'd0);
    endtask

    task automatic t_error_pause();
        int w; logic d;
        pol_now = 1'b0;
        wr(1'b0, c0(1, 0, 1, 0, 11'd3));
        next_width(w);  chk("R4 pulse before error", w, EXP_PULSE);
        strobe(1'b1, d); chk("R7 no done on error", int'(d), 0);
        rd("R7 pause set, count kept", 1'b0, c0(1, 1, 1, 0, 11'd3));
        quiet("R7 R2 halted while paused", 50);
        wr(1'b0, c0(1, 0, 1, 0, 11'd3));
        next_width(w);  chk("R7 resumed pulse", w, EXP_PULSE);
        rd("R7 same sector resumed", 1'b0, c0(1, 0, 1, 0, 11'd3));
        wr(1'b0, c0(1, 0, 1, 0, 11'd9));
        rd("R9 count write ignored mid-run", 1'b0, c0(1, 0, 1, 0, 11'd3));
        wr(1'b0, c0(0, 0, 1, 0, 11'd9));
        rd("R9 abort keeps count", 1'b0, c0(0, 0, 1, 0, 11'd3));
        wr(1'b0, c0(0, 0, 1, 0, 11'd9));
        rd("R9 count write taken when idle", 1'b0, c0(0, 0, 1, 0, 11'd9));
        quiet("R2 no request while disabled", 40);
        wr(1'b0, 16'h0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_fields();
        t_pulse_multi();
        t_polarity_high();
        t_level();
        t_error_pause();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule